// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table that sits in memory. A request brings in the virtual address and a root register, which holds the physical base of the page directory. The walker fetches one directory entry and then one table entry through a single-word read port. That port may stall for any number of cycles. The walk ends with a one-cycle response that carries either a translated address or a fault.

The virtual address splits into three fields: bits 31:22 pick one of 1024 directory slots, bits 21:12 pick one of 1024 table slots, and bits 11:0 are the byte offset within a 4 KB page. Every entry is one 32-bit word. Bit 0 of an entry is its valid flag, bits 31:12 are a frame number, and bits 11:1 are flag bits. The walker does not interpret the flag bits; it passes them out with the result so that later protection logic can use them. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `req_ready` is 1, and `rsp_done` and `mem_rd_req` are 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. From then until the response pulse, `req_ready` stays 0.
- R3: The first read address is `{root_base[31:12], 12'h000} + 4 * vaddr[31:22]`. Bits 11:0 of `root_base` have no effect.
- R4: When the directory entry has bit 0 set, the second read address is `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R5: When the directory entry has bit 0 clear, the walk ends with `rsp_fault` = 1 and no second read, so exactly one read is made.
- R6: When the table entry has bit 0 clear, the walk ends with `rsp_fault` = 1 after exactly two reads.
- R7: When both entries have bit 0 set, `rsp_fault` = 0 and `rsp_paddr` = `{table_entry[31:12], vaddr[11:0]}`.
- R8: On a successful walk, `rsp_flags` equals bits 11:1 of the table entry. The values of those bits do not change `rsp_paddr` or `rsp_fault`.
- R9: `mem_rd_req` stays 1 with a stable `mem_rd_addr` until a cycle with `mem_rd_ack` = 1, whatever the number of wait cycles. Bits 1:0 of `mem_rd_addr` are always 0.
- R10: `rsp_done` is high for exactly one cycle per accepted request, in the cycle after the acknowledge of the walk's last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Physical base of the page directory (bits 11:0 ignored) |
| rsp_done | output | 1 | One-cycle pulse when the walk ends |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_paddr | output | 32 | Translated physical address (undefined on fault) |
| rsp_flags | output | 11 | Bits 11:1 of the last entry read |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_ack | input | 1 | Read data is valid this cycle |
| mem_rd_data | input | 32 | Entry word read from memory |

## Verification
The bench goes after the early exit on an invalid directory entry. A design that always goes on to the table level would issue a second read and respond one walk later than expected. It feeds a root base with nonzero low bits, which shows whether those bits leak into the first address. It gives table entries random flag bits, which would expose a flag bit wrongly folded into the address or the fault decision. It uses random and long memory stalls, so a walker that moves on before the acknowledge, or changes its address during a stall, shows the wrong address or the wrong response timing.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_DIR  = 2'd1,
        WALK_TBL  = 2'd2
    } walk_state_e;

    localparam int unsigned ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/pw_entry_fields.sv
module pw_entry_fields #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [WORD_W-1:0]       entry,
    output logic [WORD_W-OFF_W-1:0] frame,
    output logic [OFF_W-2:0]        flags,
    output logic                    valid
);
    assign frame = entry[WORD_W-1:OFF_W];
    assign flags = entry[OFF_W-1:1];
    assign valid = entry[0];
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr
    import pt_walk_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned OFF_W  = 12
) (
    input  logic [WORD_W-OFF_W-1:0] base_frame,
    input  logic [IDX_W-1:0]        index,
    output logic [WORD_W-1:0]       entry_addr
);
    localparam int unsigned SPAN_BITS = IDX_W + ENTRY_BYTES_LOG2;

    logic [WORD_W-1:0] base_addr;
    logic [WORD_W-1:0] byte_off;

    assign base_addr = {base_frame, {OFF_W{1'b0}}};
    assign byte_off  = WORD_W'(index) << ENTRY_BYTES_LOG2;

    generate
        if (SPAN_BITS <= OFF_W) begin : g_merge
            // the whole table fits in one page: no carry, so OR is enough
            assign entry_addr = base_addr | byte_off;
        end else begin : g_add
            assign entry_addr = base_addr + byte_off;
        end
    endgenerate
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    input  logic [31:0]     root_base,
    output logic            rsp_done,
    output logic            rsp_fault,
    output logic [31:0]     rsp_paddr,
    output logic [10:0]     rsp_flags,
    output logic            mem_rd_req,
    output logic [31:0]     mem_rd_addr,
    input  logic            mem_rd_ack,
    input  logic [31:0]     mem_rd_data
);
    localparam int unsigned FRAME_W = VA_W - OFF_W;
    localparam int unsigned FLAG_W  = OFF_W - 1;
    localparam int unsigned TBL_LO  = OFF_W;
    localparam int unsigned DIR_LO  = OFF_W + IDX_W;

    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   vaddr;
        logic [VA_W-1:0]   addr;
        logic              done;
        logic              fault;
        logic [VA_W-1:0]   paddr;
        logic [FLAG_W-1:0] flags;
    } walk_regs_t;

    walk_regs_t s_d, s_q;

    logic [FRAME_W-1:0] ent_frame;
    logic [FLAG_W-1:0]  ent_flags;
    logic               ent_valid;
    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    tbl_addr;

    pw_entry_fields #(.WORD_W(VA_W), .OFF_W(OFF_W)) i_fields (
        .entry (mem_rd_data),
        .frame (ent_frame),
        .flags (ent_flags),
        .valid (ent_valid)
    );

    pw_entry_addr #(.WORD_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_dir_addr (
        .base_frame (root_base[VA_W-1:OFF_W]),
        .index      (req_vaddr[DIR_LO +: IDX_W]),
        .entry_addr (dir_addr)
    );

    pw_entry_addr #(.WORD_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_tbl_addr (
        .base_frame (ent_frame),
        .index      (s_q.vaddr[TBL_LO +: IDX_W]),
        .entry_addr (tbl_addr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    s_d.vaddr = req_vaddr;
                    s_d.addr  = dir_addr;
                    s_d.state = WALK_DIR;
                end
            end
            WALK_DIR: begin
                if (mem_rd_ack) begin
                    if (ent_valid) begin
                        s_d.addr  = tbl_addr;
                        s_d.state = WALK_TBL;
                    end else begin
                        s_d.done  = 1'b1;
                        s_d.fault = 1'b1;
                        s_d.flags = ent_flags;
                        s_d.state = WALK_IDLE;
                    end
                end
            end
            WALK_TBL: begin
                if (mem_rd_ack) begin
                    s_d.done  = 1'b1;
                    s_d.fault = ~ent_valid;
                    s_d.paddr = {ent_frame, s_q.vaddr[OFF_W-1:0]};
                    s_d.flags = ent_flags;
                    s_d.state = WALK_IDLE;
                end
            end
            default: s_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: WALK_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.state == WALK_IDLE);
    assign mem_rd_req  = (s_q.state != WALK_IDLE);
    assign mem_rd_addr = s_q.addr;
    assign rsp_done    = s_q.done;
    assign rsp_fault   = s_q.fault;
    assign rsp_paddr   = s_q.paddr;
    assign rsp_flags   = s_q.flags;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        rsp_done,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_ack,
    input logic [31:0] mem_rd_data
);
    logic        lvl_q;
    logic [11:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            off_q <= '0;
        end else if (req_valid && req_ready) begin
            lvl_q <= 1'b0;
            off_q <= req_vaddr[11:0];
        end else if (mem_rd_req && mem_rd_ack) begin
            lvl_q <= 1'b1;
        end
    end

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R9
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

    // R5
    dir_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && !lvl_q && !mem_rd_data[0])
            |=> (rsp_done && rsp_fault && !mem_rd_req));

    // R7
    tbl_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_ack && lvl_q && mem_rd_data[0])
            |=> (rsp_done && !rsp_fault && rsp_paddr[11:0] == off_q));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind pt_walker pw_checker i_pw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .rsp_done    (rsp_done),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_data (mem_rd_data)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] root_base = '0;
    logic        rsp_done, rsp_fault;
    logic [31:0] rsp_paddr;
    logic [10:0] rsp_flags;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem [int unsigned];

    int          nreads = 0;
    logic [31:0] rd_addr [0:3];
    int          ack_cyc = 0;
    int          lat_max = 3;
    int          wcnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .root_base(root_base),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_flags(rsp_flags),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // memory responder with variable latency
    always @(negedge clk) begin
        if (mem_rd_ack) begin
            mem_rd_ack = 1'b0;
        end else if (rst_n && mem_rd_req) begin
            if (!pend) begin
                pend = 1'b1;
                pend_addr = mem_rd_addr;
                wcnt = (lat_max == 0) ? 0 : int'($urandom_range(lat_max));
                chk(req_ready == 1'b0, "R2 ready low while walking", {31'b0, req_ready}, 32'h0);
                chk(mem_rd_addr[1:0] == 2'b00, "R9 aligned address", mem_rd_addr, {mem_rd_addr[31:2], 2'b00});
            end else begin
                chk(mem_rd_addr == pend_addr, "R9 address stable during stall", mem_rd_addr, pend_addr);
            end
            if (wcnt == 0) begin
                mem_rd_ack = 1'b1;
                mem_rd_data = rd(mem_rd_addr);
                if (nreads < 4) rd_addr[nreads] = mem_rd_addr;
                nreads++;
                ack_cyc = cyc;
                pend = 1'b0;
            end else begin
                wcnt--;
            end
        end
    end

    // reference model: returns fault, paddr, flags, read count and addresses
    task automatic ref_walk(input logic [31:0] root, input logic [31:0] va,
                            output bit flt, output logic [31:0] pa, output logic [10:0] fl,
                            output int n, output logic [31:0] a0, output logic [31:0] a1);
        logic [31:0] de, te;
        a0 = {root[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
        de = rd(a0);
        a1 = '0; pa = '0;
        if (!de[0]) begin
            flt = 1'b1; n = 1; fl = de[11:1];
            return;
        end
        a1 = {de[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
        te = rd(a1);
        n = 2; flt = !te[0]; fl = te[11:1];
        pa = {te[31:12], va[11:0]};
    endtask

    task automatic walk(input logic [31:0] root, input logic [31:0] va, input string tag);
        bit e_flt; logic [31:0] e_pa, a0, a1; logic [10:0] e_fl; int e_n;
        int guard;
        ref_walk(root, va, e_flt, e_pa, e_fl, e_n, a0, a1);
        @(negedge clk);
        nreads = 0;
        chk(req_ready == 1'b1, {"R2 ready when idle ", tag}, {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = va; root_base = root;
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = $urandom; root_base = $urandom;
        guard = 0;
        while (!rsp_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_done == 1'b1, {"R10 response arrives ", tag}, {31'b0, rsp_done}, 32'h1);
        chk(cyc == ack_cyc + 1, {"R10 done one cycle after last ack ", tag}, cyc, ack_cyc + 1);
        chk(nreads == e_n, {(e_n == 1) ? "R5 read count " : "R6 read count ", tag}, nreads, e_n);
        chk(rd_addr[0] == a0, {"R3 first read address ", tag}, rd_addr[0], a0);
        if (e_n == 2 && nreads >= 2)
            chk(rd_addr[1] == a1, {"R4 second read address ", tag}, rd_addr[1], a1);
        chk(rsp_fault == e_flt, {e_flt ? "R5/R6 fault " : "R7 no fault ", tag}, {31'b0, rsp_fault}, {31'b0, e_flt});
        if (!e_flt) begin
            chk(rsp_paddr == e_pa, {"R7 physical address ", tag}, rsp_paddr, e_pa);
            chk(rsp_flags == e_fl, {"R8 flags ", tag}, {21'b0, rsp_flags}, {21'b0, e_fl});
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, {"R10 single-cycle pulse ", tag}, {31'b0, rsp_done}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // directed tables
        mem[32'h1004] = 32'h1001; mem[32'h1008] = 32'h5001; mem[32'h100c] = 32'h8001;
        mem[32'h5004] = 32'h4e001; mem[32'h5008] = 32'h67001; mem[32'h500c] = 32'h20001;
        mem[32'h8000] = 32'h9000; mem[32'h8004] = 32'h326001; mem[32'h8008] = 32'h4f001;

        repeat (2) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
        chk(rsp_done == 1'b0, "R1 done low in reset", {31'b0, rsp_done}, 32'h0);
        chk(mem_rd_req == 1'b0, "R1 no read in reset", {31'b0, mem_rd_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_rd_req == 1'b0 && rsp_done == 1'b0,
            "R1 idle after reset", {29'b0, req_ready, mem_rd_req, rsp_done}, 32'h4);

        // directed cases
        walk(32'h1000, 32'h0000_0000, "dir invalid R5");
        walk(32'h1000, 32'h0080_3024, "valid walk R7");
        walk(32'h1000, 32'h00c0_0136, "table invalid R6");
        walk(32'h1000, 32'h0040_2004, "table maps directory");
        walk(32'h1abc, 32'h0080_3fff, "root low bits ignored R3");
        mem[32'h500c] = 32'h20ffe;
        walk(32'h1000, 32'h0080_3024, "flags set, valid clear R6");
        mem[32'h500c] = 32'h20fff;
        walk(32'h1000, 32'h0080_3024, "all flags set R8");
        lat_max = 0;
        walk(32'h1000, 32'h0080_3100, "zero wait R9");
        lat_max = 20;
        walk(32'h1000, 32'h0080_3200, "long wait R9");
        lat_max = 3;

        // random tables: roots at frames 2 and 3, tables at frames 0x10..0x17
        for (int r = 2; r < 4; r++)
            for (int d = 0; d < 8; d++)
                mem[32'(r << 12) + 32'(d * 4)] =
                    {12'h0, 8'h10 + 8'($urandom_range(7)), 11'($urandom), ($urandom_range(3) != 0)};
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 8; i++)
                mem[32'((16 + t) << 12) + 32'(i * 4)] =
                    {20'($urandom), 11'($urandom), ($urandom_range(4) != 0)};

        for (int k = 0; k < 150; k++) begin
            logic [31:0] root, va;
            root = {20'(2 + $urandom_range(1)), 12'($urandom)};
            va = {10'($urandom_range(9)), 10'($urandom_range(9)), 12'($urandom)};
            walk(root, va, "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule